// File: doc/BRIEF.md
# Stereo PGA Gain Control Register

This block keeps the left and right gain settings of a stereo programmable-gain input stage and drives the 7-bit gain codes that the analog stage actually uses. Software writes a gain code per channel over a simple address/data bus and can read it back. Four power-enable inputs, an automatic-level-control (ALC) enable and a pair of gain codes from the level-control engine decide whether a write reaches the analog stage, when the stage falls back to its default, and what it keeps when level control hands back. The stored register value and the applied gain are kept apart, so readback always shows the last write and not the live gain.

The gain code steps in 0.5 dB. On the microphone path code 0x10 is 0 dB, code 0x00 is -8.0 dB and the top code 0x47 is +27.5 dB; the line path sits 15.5 dB lower for the same code. For checking, each channel's applied gain is also given in signed half-dB units relative to the 0 dB code of the microphone path.

A small shared mode machine sequences the channels. Its states are `ST_PWR_DOWN` (no power-enable bit is set; gains held at default), `ST_MANUAL` (powered, bus writes reach the gain) and `ST_ALC_RUN` (powered, the level-control engine drives the gain). Transitions: any state to `ST_PWR_DOWN` when all power bits are 0; `ST_PWR_DOWN` to `ST_MANUAL` or `ST_ALC_RUN` when any power bit is 1, picked by the ALC enable; `ST_MANUAL` to `ST_ALC_RUN` when ALC turns on; `ST_ALC_RUN` to `ST_MANUAL` when ALC turns off.

Top module: `stereo_pga_gain_ctl`

## Requirements
- R1: The left gain register sits at address 0x0B and the right at 0x0F. A read of either returns 0 in bit 7 and, in bits 6..0, the code of the last write to it, whether or not that write reached the applied gain; any other address reads 0x00, and a write to any other address changes neither register nor gain.
- R2: A synchronous active-high reset sets both register values and both applied gains to 0x10 and the mode machine to `ST_PWR_DOWN`; a write during reset is lost.
- R3: A write changes that channel's applied gain one clock later only if, in the write cycle, the mode machine is not in `ST_PWR_DOWN`, at least one power-enable bit is 1 and ALC is off.
- R4: An applied gain never exceeds 0x47: a written or ALC-supplied code above 0x47 is applied as 0x47, while a written raw code is still kept for readback.
- R5: In any cycle where all four power-enable bits are 0, both applied gains become 0x10 one clock later, ALC input and writes notwithstanding.
- R6: In the first powered cycle after power-down (state `ST_PWR_DOWN` with a power bit now 1) the gains stay at 0x10, so operation restarts from default, not from the stored register value; a write in that cycle is stored but not applied.
- R7: While powered, not in `ST_PWR_DOWN` and ALC on, each cycle with the ALC-valid input high loads both applied gains (clamped per R4) from the engine's codes one clock later; cycles with ALC-valid low and all bus writes leave the gains unchanged.
- R8: When ALC turns off, the applied gains keep the last values the engine set until a later applied write, power-down or reset.
- R9: The half-dB outputs equal the applied code minus 16 as an 8-bit two's complement value (code 0x00 gives -16, 0x10 gives 0, 0x47 gives 55).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 7 | Gain code to write (bit 7 of the register is read-only) |
| bus_rdata | output | 8 | Readback of the addressed register, combinational |
| pwr_en | input | 4 | Power-enable bits; any 1 powers the stage |
| alc_on | input | 1 | Automatic level control enable |
| alc_valid | input | 1 | Engine codes are valid this cycle |
| alc_gain_l | input | 7 | Left gain code from the level-control engine |
| alc_gain_r | input | 7 | Right gain code from the level-control engine |
| gain_l | output | 7 | Applied left gain code |
| gain_r | output | 7 | Applied right gain code |
| gain_hdb_l | output | 8 | Applied left gain in signed half-dB units |
| gain_hdb_r | output | 8 | Applied right gain in signed half-dB units |

## Verification
The bench targets the places where readback and applied gain part ways: a write made on the restart cycle, which a design that skipped the power-down state would apply at once, and a write made while ALC runs, which a design that did not gate writes would let through to the analog stage. It turns ALC off after the engine set an out-of-range code, so a design that reverted to the register or forgot to clamp engine codes shows a wrong gain, and it powers back up after writes to check that gains restart at 0x10 rather than at the stored code. Unmapped addresses, a full-scale write and the -16 half-dB floor catch a loose address decode, a lost raw readback value and an unsigned offset.

// File: rtl/pga_gain_pkg.sv
package pga_gain_pkg;

    // Shared mode of both channels
    typedef enum logic [1:0] {
        ST_PWR_DOWN = 2'd0,
        ST_MANUAL   = 2'd1,
        ST_ALC_RUN  = 2'd2
    } pga_mode_e;

endpackage

// File: rtl/pga_mode_fsm.sv
module pga_mode_fsm
    import pga_gain_pkg::*;
#(
    parameter int NUM_PWR = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PWR-1:0] pwr_en,
    input  logic               alc_on,
    output pga_mode_e          mode,
    output logic               force_default,
    output logic               wr_allow,
    output logic               follow_alc
);

    logic      pwr_any;
    pga_mode_e mode_nxt;

    assign pwr_any = |pwr_en;

    // Next-state decision
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            ST_PWR_DOWN: if (pwr_any) mode_nxt = alc_on ? ST_ALC_RUN : ST_MANUAL;
            ST_MANUAL: begin
                if (!pwr_any)    mode_nxt = ST_PWR_DOWN;
                else if (alc_on) mode_nxt = ST_ALC_RUN;
            end
            ST_ALC_RUN: begin
                if (!pwr_any)     mode_nxt = ST_PWR_DOWN;
                else if (!alc_on) mode_nxt = ST_MANUAL;
            end
            default: mode_nxt = ST_PWR_DOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) mode <= ST_PWR_DOWN;
        else     mode <= mode_nxt;
    end

    // Control outputs
    always_comb begin
        force_default = 1'b0;
        wr_allow      = 1'b0;
        follow_alc    = 1'b0;
        unique case (mode)
            ST_PWR_DOWN: force_default = 1'b1;
            ST_MANUAL, ST_ALC_RUN: begin
                force_default = !pwr_any;
                wr_allow      = pwr_any && !alc_on;
                follow_alc    = pwr_any && alc_on;
            end
            default: force_default = 1'b1;
        endcase
    end

endmodule

// File: rtl/pga_gain_chan.sv
module pga_gain_chan #(
    parameter int CODE_W   = 7,
    parameter int DEF_CODE = 16,
    parameter int MAX_CODE = 71
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              force_default,
    input  logic              wr_allow,
    input  logic              follow_alc,
    input  logic              alc_valid,
    input  logic [CODE_W-1:0] alc_code,
    output logic [CODE_W-1:0] reg_code,
    output logic [CODE_W-1:0] gain_code
);

    localparam logic [CODE_W-1:0] DEF_C = CODE_W'(DEF_CODE);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] wr_lim;
    logic [CODE_W-1:0] alc_lim;

    assign wr_lim  = (wr_code  > MAX_C) ? MAX_C : wr_code;
    assign alc_lim = (alc_code > MAX_C) ? MAX_C : alc_code;

    // Readback register: last written raw code
    always_ff @(posedge clk) begin
        if (rst)         reg_code <= DEF_C;
        else if (wr_hit) reg_code <= wr_code;
    end

    // Applied gain: default, engine, or gated write
    always_ff @(posedge clk) begin
        if (rst)                          gain_code <= DEF_C;
        else if (force_default)           gain_code <= DEF_C;
        else if (follow_alc && alc_valid) gain_code <= alc_lim;
        else if (wr_allow && wr_hit)      gain_code <= wr_lim;
    end

endmodule

// File: rtl/stereo_pga_gain_ctl.sv
module stereo_pga_gain_ctl
    import pga_gain_pkg::*;
#(
    parameter int                CODE_W       = 7,
    parameter int                ADDR_W       = 8,
    parameter int                NUM_PWR      = 4,
    parameter int                DEF_CODE     = 16,
    parameter int                MAX_CODE     = 71,
    parameter int                ZERO_DB_CODE = 16,
    parameter logic [ADDR_W-1:0] ADDR_LEFT    = 8'h0B,
    parameter logic [ADDR_W-1:0] ADDR_RIGHT   = 8'h0F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CODE_W-1:0]  bus_wdata,
    output logic [CODE_W:0]    bus_rdata,
    input  logic [NUM_PWR-1:0] pwr_en,
    input  logic               alc_on,
    input  logic               alc_valid,
    input  logic [CODE_W-1:0]  alc_gain_l,
    input  logic [CODE_W-1:0]  alc_gain_r,
    output logic [CODE_W-1:0]  gain_l,
    output logic [CODE_W-1:0]  gain_r,
    output logic [CODE_W:0]    gain_hdb_l,
    output logic [CODE_W:0]    gain_hdb_r
);

    localparam int NUM_CH = 2;
    localparam int HDB_W  = CODE_W + 1;

    pga_mode_e         mode;
    logic              force_default;
    logic              wr_allow;
    logic              follow_alc;
    logic [CODE_W-1:0] alc_code [NUM_CH];
    logic [CODE_W-1:0] reg_code [NUM_CH];
    logic [CODE_W-1:0] gain_code[NUM_CH];

    assign alc_code[0] = alc_gain_l;
    assign alc_code[1] = alc_gain_r;

    pga_mode_fsm #(.NUM_PWR(NUM_PWR)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .pwr_en        (pwr_en),
        .alc_on        (alc_on),
        .mode          (mode),
        .force_default (force_default),
        .wr_allow      (wr_allow),
        .follow_alc    (follow_alc)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam logic [ADDR_W-1:0] CH_ADDR = (ch == 0) ? ADDR_LEFT : ADDR_RIGHT;
        logic hit;
        assign hit = bus_wr && (bus_addr == CH_ADDR);

        pga_gain_chan #(
            .CODE_W   (CODE_W),
            .DEF_CODE (DEF_CODE),
            .MAX_CODE (MAX_CODE)
        ) u_chan (
            .clk           (clk),
            .rst           (rst),
            .wr_hit        (hit),
            .wr_code       (bus_wdata),
            .force_default (force_default),
            .wr_allow      (wr_allow),
            .follow_alc    (follow_alc),
            .alc_valid     (alc_valid),
            .alc_code      (alc_code[ch]),
            .reg_code      (reg_code[ch]),
            .gain_code     (gain_code[ch])
        );
    end

    // Readback: bit 7 always 0
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LEFT)       bus_rdata = {1'b0, reg_code[0]};
        else if (bus_addr == ADDR_RIGHT) bus_rdata = {1'b0, reg_code[1]};
    end

    assign gain_l     = gain_code[0];
    assign gain_r     = gain_code[1];
    assign gain_hdb_l = HDB_W'(gain_code[0]) - HDB_W'(ZERO_DB_CODE);
    assign gain_hdb_r = HDB_W'(gain_code[1]) - HDB_W'(ZERO_DB_CODE);

endmodule

// File: rtl/stereo_pga_gain_ctl_chk.sv
module stereo_pga_gain_ctl_chk #(
    parameter int                CODE_W    = 7,
    parameter int                ADDR_W    = 8,
    parameter int                NUM_PWR   = 4,
    parameter int                DEF_CODE  = 16,
    parameter int                MAX_CODE  = 71,
    parameter logic [ADDR_W-1:0] ADDR_LEFT = 8'h0B
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [CODE_W-1:0]  bus_wdata,
    input logic [CODE_W:0]    bus_rdata,
    input logic [NUM_PWR-1:0] pwr_en,
    input logic               alc_on,
    input logic               alc_valid,
    input logic [CODE_W-1:0]  gain_l,
    input logic [CODE_W-1:0]  gain_r
);

    // R1
    readback_l_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr && bus_addr == ADDR_LEFT) && bus_addr == ADDR_LEFT)
        |-> bus_rdata == {1'b0, $past(bus_wdata)});

    // R4
    gain_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_l <= CODE_W'(MAX_CODE)) && (gain_r <= CODE_W'(MAX_CODE)));

    // R5
    pwrdn_default_chk: assert property (@(posedge clk) disable iff (rst)
        !(|pwr_en) |=> (gain_l == CODE_W'(DEF_CODE)) && (gain_r == CODE_W'(DEF_CODE)));

    // R6
    restart_default_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|pwr_en) |=> (gain_l == CODE_W'(DEF_CODE)) && (gain_r == CODE_W'(DEF_CODE)));

    // R7
    alc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (alc_on && !alc_valid && (|pwr_en)) |=> $stable(gain_l) && $stable(gain_r));

    // R8
    alc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(alc_on) && !bus_wr) |=> $stable(gain_l) && $stable(gain_r));

endmodule

bind stereo_pga_gain_ctl stereo_pga_gain_ctl_chk #(
    .CODE_W    (CODE_W),
    .ADDR_W    (ADDR_W),
    .NUM_PWR   (NUM_PWR),
    .DEF_CODE  (DEF_CODE),
    .MAX_CODE  (MAX_CODE),
    .ADDR_LEFT (ADDR_LEFT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwr_en    (pwr_en),
    .alc_on    (alc_on),
    .alc_valid (alc_valid),
    .gain_l    (gain_l),
    .gain_r    (gain_r)
);

// File: tb/stereo_pga_gain_ctl_bench.sv
module stereo_pga_gain_ctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [6:0] bus_wdata = 7'h00;
    logic [7:0] bus_rdata;
    logic [3:0] pwr_en = 4'h0;
    logic       alc_on = 1'b0;
    logic       alc_valid = 1'b0;
    logic [6:0] alc_gain_l = 7'h00;
    logic [6:0] alc_gain_r = 7'h00;
    logic [6:0] gain_l, gain_r;
    logic [7:0] gain_hdb_l, gain_hdb_r;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    stereo_pga_gain_ctl u_stereo_pga_gain_ctl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
        .alc_on(alc_on), .alc_valid(alc_valid), .alc_gain_l(alc_gain_l),
        .alc_gain_r(alc_gain_r), .gain_l(gain_l), .gain_r(gain_r),
        .gain_hdb_l(gain_hdb_l), .gain_hdb_r(gain_hdb_r)
    );

    typedef struct packed {
        logic [3:0] pwr;
        logic       alc;
        logic       av;
        logic [6:0] al;
        logic [6:0] ar;
        logic       wr;
        logic [7:0] addr;
        logic [6:0] wd;
        logic [6:0] exp_l;
        logic [6:0] exp_r;
        logic [7:0] exp_rd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R6: write on restart cycle stored, not applied
        '{4'h1,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0B,7'h20,7'h10,7'h10,8'h20},
        // R3: applied write
        '{4'h1,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0B,7'h20,7'h20,7'h10,8'h20},
        '{4'h2,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0F,7'h05,7'h20,7'h05,8'h05},
        // R4: clamp, raw readback
        '{4'h1,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0B,7'h7F,7'h47,7'h05,8'h7F},
        '{4'h4,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0F,7'h47,7'h47,7'h47,8'h47},
        // R9: floor code
        '{4'h8,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0B,7'h00,7'h00,7'h47,8'h00},
        // R7: ALC follow
        '{4'h8,1'b1,1'b1,7'h30,7'h31,1'b0,8'h0B,7'h00,7'h30,7'h31,8'h00},
        // R7: write and invalid engine cycle ignored; R1 readback updates
        '{4'h8,1'b1,1'b0,7'h11,7'h12,1'b1,8'h0B,7'h05,7'h30,7'h31,8'h05},
        // R4 R7: engine code clamped
        '{4'h8,1'b1,1'b1,7'h7F,7'h00,1'b0,8'h0F,7'h00,7'h47,7'h00,8'h47},
        // R8: hold on ALC off
        '{4'h8,1'b0,1'b1,7'h22,7'h22,1'b0,8'h0B,7'h00,7'h47,7'h00,8'h05},
        '{4'h8,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0F,7'h15,7'h47,7'h15,8'h15},
        // R5: power-down, write stored only
        '{4'h0,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0B,7'h33,7'h10,7'h10,8'h33},
        // R1: unmapped read
        '{4'h0,1'b0,1'b0,7'h00,7'h00,1'b0,8'h0C,7'h00,7'h10,7'h10,8'h00},
        // R6: restart
        '{4'h2,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0F,7'h40,7'h10,7'h10,8'h40},
        '{4'h2,1'b0,1'b0,7'h00,7'h00,1'b0,8'h0B,7'h00,7'h10,7'h10,8'h33},
        // R1: unmapped write
        '{4'h2,1'b0,1'b0,7'h00,7'h00,1'b1,8'h0C,7'h44,7'h10,7'h10,8'h00},
        '{4'h3,1'b1,1'b1,7'h02,7'h03,1'b0,8'h0F,7'h00,7'h02,7'h03,8'h40},
        // R5: power-down beats ALC
        '{4'h0,1'b1,1'b1,7'h09,7'h09,1'b0,8'h0F,7'h00,7'h10,7'h10,8'h40}
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag, input logic [6:0] el, input logic [6:0] er,
                                 input logic [7:0] erd);
        chk({tag, " gain_l (R3,R5,R6,R7,R8)"}, {1'b0, gain_l}, {1'b0, el});
        chk({tag, " gain_r (R3,R5,R6,R7,R8)"}, {1'b0, gain_r}, {1'b0, er});
        chk({tag, " hdb_l (R9)"}, gain_hdb_l, 8'(int'(el) - 16));
        chk({tag, " hdb_r (R9)"}, gain_hdb_r, 8'(int'(er) - 16));
        chk({tag, " rdata (R1)"}, bus_rdata, erd);
    endtask

    initial begin
        // R2: reset state
        repeat (3) @(posedge clk);
        #2;
        bus_addr = 8'h0B;
        #1;
        check_outputs("reset R2", 7'h10, 7'h10, 8'h10);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            pwr_en     = VECS[i].pwr;
            alc_on     = VECS[i].alc;
            alc_valid  = VECS[i].av;
            alc_gain_l = VECS[i].al;
            alc_gain_r = VECS[i].ar;
            bus_wr     = VECS[i].wr;
            bus_addr   = VECS[i].addr;
            bus_wdata  = VECS[i].wd;
            @(posedge clk);
            #2;
            check_outputs($sformatf("vec %0d", i), VECS[i].exp_l, VECS[i].exp_r, VECS[i].exp_rd);
            @(negedge clk);
        end

        // Directed: set a gain, then reset while powered with a write (R2)
        bus_wr = 1'b0; alc_on = 1'b0; alc_valid = 1'b0; pwr_en = 4'h1;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0B; bus_wdata = 7'h3C;
        @(posedge clk); #2;
        check_outputs("pre-reset R3", 7'h3C, 7'h10, 8'h3C);
        @(negedge clk);
        rst = 1'b1; bus_wdata = 7'h2A;
        @(posedge clk); #2;
        check_outputs("reset write R2", 7'h10, 7'h10, 8'h10);
        @(negedge clk);
        // First cycle after reset is the restart cycle (R6)
        rst = 1'b0;
        @(posedge clk); #2;
        check_outputs("restart R6", 7'h10, 7'h10, 8'h2A);
        @(negedge clk);
        bus_wdata = 7'h00;
        @(posedge clk); #2;
        check_outputs("floor R9", 7'h00, 7'h10, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h0F;
        #2;
        chk("right readback R1", bus_rdata, 8'h10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired (R2) actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule